// File: doc/BRIEF.md
# Working-Set Clock Eviction Scanner

This block chooses which page frame to give up when a new page must be brought in. For each of a fixed number of frames it holds a reference flag and a stamp that records when the frame was last seen in use. It also keeps a virtual-time counter that advances on a tick input. Reference pulses mark frames as recently used. An eviction request starts a circular sweep from a persistent hand position. The sweep looks at one frame per clock cycle.

During the sweep, a frame whose flag is set has its stamp refreshed to the current time, its flag is cleared, and it is passed over. A frame with a clear flag whose age exceeds a programmable window is taken at once. Age is the current time minus the stamp, computed modulo the counter width. If a whole revolution finds no such frame, the scanner falls back to the oldest clear-flag frame it saw. The chosen frame is treated as freshly loaded: its stamp takes the current time, its flag is set, and the hand moves to the slot after it. Completion is reported by a one-cycle strobe along with the frame index.

Top module: `wsclock_scanner`

## Requirements
- R1: After reset, `busy` and `victim_valid` are 0. The virtual time is 0, every reference flag is clear, every stamp is 0, and the hand points at frame 0.
- R2: Each cycle with `tick` high advances the virtual time by one, wrapping modulo 2^TW. Without `tick` the time holds.
- R3: A cycle with `ref_valid` high sets the reference flag of frame `ref_idx`. The flag stays set until a sweep clears it or the frame is installed.
- R4: `evict_req` while idle starts a sweep at the hand. Frames are examined one per cycle in increasing index order, wrapping from NFRAMES-1 to 0. `evict_req` while a sweep is running is ignored.
- R5: A swept frame with its flag set gets its stamp set to the current time, has its flag cleared, and is not chosen at that step.
- R6: A swept frame with its flag clear is chosen immediately when (now - stamp) mod 2^TW is strictly greater than `thresh`. An age equal to `thresh` does not qualify.
- R7: If NFRAMES frames are examined with none qualifying under R6, the victim is the clear-flag frame with the largest age. Ties go to the one examined first. If no clear-flag frame was seen, the victim is the frame where the sweep started.
- R8: `victim_valid` is a one-cycle pulse with `victim_idx`. It is registered on the edge that examines the deciding frame, so the number of cycles from the request edge to the pulse equals the number of frames examined (1 to NFRAMES).
- R9: The victim is installed: its stamp becomes the current time, its flag is set, and the hand moves to the frame after it.
- R10: `busy` is high from the edge after the request until the victim is reported, and it is low in the cycle where `victim_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Advance virtual time by one |
| ref_valid | input | 1 | Reference pulse strobe |
| ref_idx | input | IW | Frame being referenced |
| thresh | input | TW | Working-set window (age limit) |
| evict_req | input | 1 | Start a sweep (honoured only while idle) |
| busy | output | 1 | Sweep in progress |
| victim_valid | output | 1 | One-cycle completion strobe |
| victim_idx | output | IW | Chosen frame |

## Verification
The bench builds the scanner with NFRAMES=6 and TW=5. Six frames is not a power of two, so the hand must wrap explicitly from index 5 back to 0. A 5-bit clock wraps after 32 ticks, so the random tick stream regularly forces the modular age subtraction across the rollover. With a small window and only six frames, a single run reaches every sweep outcome many times: immediate eviction, age exactly equal to the window, fallback to the oldest frame, and fallback to the starting frame when every flag was set.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;
endpackage

// File: rtl/wsc_vclock.sv
module wsc_vclock #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [TW-1:0] vnow
);
  always_ff @(posedge clk) begin
    if (rst) vnow <= '0;
    else if (tick) vnow <= vnow + 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(vnow));
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> vnow == $past(vnow) + 1'b1);
endmodule

// File: rtl/wsc_frame_table.sv
module wsc_frame_table #(
  parameter int N  = 8,
  parameter int TW = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] vnow,
  input  logic          ref_valid,
  input  logic [IW-1:0] ref_idx,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic          inst_en,
  input  logic [IW-1:0] inst_idx,
  output logic [N-1:0]  rbits,
  output logic [TW-1:0] stamps [N]
);
  for (genvar g = 0; g < N; g++) begin : g_frame
    logic hit_ref, hit_touch, hit_inst;
    assign hit_ref   = ref_valid && (ref_idx == IW'(g));
    assign hit_touch = touch_en && (touch_idx == IW'(g));
    assign hit_inst  = inst_en && (inst_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        rbits[g]  <= 1'b0;
        stamps[g] <= '0;
      end else begin
        if (hit_touch || hit_inst) stamps[g] <= vnow;
        // a fresh reference or an install wins over a sweep clear
        if (hit_ref || hit_inst) rbits[g] <= 1'b1;
        else if (hit_touch)      rbits[g] <= 1'b0;
      end
    end
  end

  assert_ref_sets_R3: assert property (@(posedge clk) disable iff (rst)
    ref_valid |=> rbits[$past(ref_idx)]);
  assert_install_R9: assert property (@(posedge clk) disable iff (rst)
    inst_en |=> rbits[$past(inst_idx)] && (stamps[$past(inst_idx)] == $past(vnow)));
  assert_touch_stamp_R5: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> stamps[$past(touch_idx)] == $past(vnow));
endmodule

// File: rtl/wsc_scan_ctrl.sv
module wsc_scan_ctrl
  import wsc_pkg::*;
#(
  parameter int N  = 8,
  parameter int TW = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evict_req,
  input  logic [TW-1:0] thresh,
  input  logic [TW-1:0] vnow,
  input  logic [N-1:0]  rbits,
  input  logic [TW-1:0] stamps [N],
  output logic          touch_en,
  output logic [IW-1:0] touch_idx,
  output logic          inst_en,
  output logic [IW-1:0] inst_idx,
  output logic          busy,
  output logic          victim_valid,
  output logic [IW-1:0] victim_idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  scan_state_t   state;
  logic [IW-1:0] hand, start, cand, cnt;
  logic [TW-1:0] cand_age, cur_age;
  logic          have, scanning, cur_ref, hit, better, fall;
  logic [IW-1:0] fall_idx;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  assign scanning = (state == ST_SCAN);
  assign cur_ref  = rbits[hand];
  assign cur_age  = vnow - stamps[hand];
  assign hit      = scanning && !cur_ref && (cur_age > thresh);
  assign better   = !cur_ref && (!have || (cur_age > cand_age));
  assign fall     = scanning && !hit && (cnt == LAST);
  assign fall_idx = better ? hand : (have ? cand : start);

  assign touch_en  = scanning && cur_ref;
  assign touch_idx = hand;
  assign inst_en   = hit || fall;
  assign inst_idx  = hit ? hand : fall_idx;
  assign busy      = scanning;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      hand         <= '0;
      start        <= '0;
      cand         <= '0;
      cand_age     <= '0;
      cnt          <= '0;
      have         <= 1'b0;
      victim_valid <= 1'b0;
      victim_idx   <= '0;
    end else begin
      victim_valid <= 1'b0;
      if (!scanning) begin
        if (evict_req) begin
          state <= ST_SCAN;
          start <= hand;
          cnt   <= '0;
          have  <= 1'b0;
        end
      end else if (inst_en) begin
        state        <= ST_IDLE;
        victim_valid <= 1'b1;
        victim_idx   <= inst_idx;
        hand         <= nxt(inst_idx);
      end else begin
        if (better) begin
          have     <= 1'b1;
          cand     <= hand;
          cand_age <= cur_age;
        end
        hand <= nxt(hand);
        cnt  <= cnt + 1'b1;
      end
    end
  end

  assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    victim_valid |=> !victim_valid);
  assert_idx_range_R8: assert property (@(posedge clk) disable iff (rst)
    victim_valid |-> victim_idx <= LAST);
  assert_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    (scanning && cnt == LAST) |=> !busy && victim_valid);
  assert_busy_low_R10: assert property (@(posedge clk) disable iff (rst)
    victim_valid |-> !busy);
  assert_start_R4: assert property (@(posedge clk) disable iff (rst)
    (!scanning && evict_req) |=> busy && hand == $past(hand));
endmodule

// File: rtl/wsclock_scanner.sv
module wsclock_scanner #(
  parameter  int NFRAMES = 8,
  parameter  int TW      = 16,
  localparam int IW      = $clog2(NFRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ref_valid,
  input  logic [IW-1:0] ref_idx,
  input  logic [TW-1:0] thresh,
  input  logic          evict_req,
  output logic          busy,
  output logic          victim_valid,
  output logic [IW-1:0] victim_idx
);
  logic [TW-1:0]      vnow;
  logic [NFRAMES-1:0] rbits;
  logic [TW-1:0]      stamps [NFRAMES];
  logic               touch_en, inst_en;
  logic [IW-1:0]      touch_idx, inst_idx;

  wsc_vclock #(.TW(TW)) u_clock (
    .clk(clk), .rst(rst), .tick(tick), .vnow(vnow)
  );

  wsc_frame_table #(.N(NFRAMES), .TW(TW), .IW(IW)) u_table (
    .clk(clk), .rst(rst), .vnow(vnow),
    .ref_valid(ref_valid), .ref_idx(ref_idx),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .inst_en(inst_en), .inst_idx(inst_idx),
    .rbits(rbits), .stamps(stamps)
  );

  wsc_scan_ctrl #(.N(NFRAMES), .TW(TW), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .evict_req(evict_req), .thresh(thresh),
    .vnow(vnow), .rbits(rbits), .stamps(stamps),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .inst_en(inst_en), .inst_idx(inst_idx),
    .busy(busy), .victim_valid(victim_valid), .victim_idx(victim_idx)
  );

  assert_victim_loaded_R9: assert property (@(posedge clk) disable iff (rst)
    victim_valid |-> rbits[victim_idx]);
endmodule

// File: tb/wsclock_scanner_test.sv
`timescale 1ns/1ps
module wsclock_scanner_test;
  localparam int N    = 6;
  localparam int TW   = 5;
  localparam int IW   = $clog2(N);
  localparam int MASK = (1 << TW) - 1;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, ref_valid = 1'b0, evict_req = 1'b0;
  logic [IW-1:0] ref_idx = '0;
  logic [TW-1:0] thresh = '0;
  logic busy, victim_valid;
  logic [IW-1:0] victim_idx;

  int errors = 0, checks = 0;
  bit finished = 0;
  int mrb [N];
  int mst [N];
  int mvt, mhand;

  always #4 clk = ~clk;

  wsclock_scanner #(.NFRAMES(N), .TW(TW)) uut (
    .clk(clk), .rst(rst), .tick(tick), .ref_valid(ref_valid), .ref_idx(ref_idx),
    .thresh(thresh), .evict_req(evict_req), .busy(busy),
    .victim_valid(victim_valid), .victim_idx(victim_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model of one sweep (R4-R9); returns victim and frames examined.
  function automatic void model_scan(output int v, output int k);
    int cand = 0, cage = 0, st0 = mhand, age;
    bit have = 0, done = 0;
    v = 0; k = 0;
    for (int i = 1; i <= N && !done; i++) begin
      int f = mhand;
      k = i;
      if (mrb[f] != 0) begin
        mst[f] = mvt; mrb[f] = 0;
      end else begin
        age = (mvt - mst[f]) & MASK;
        if (age > int'(thresh)) begin v = f; done = 1; end
        else if (!have || age > cage) begin cand = f; cage = age; have = 1; end
      end
      if (!done && i == N) begin v = have ? cand : st0; done = 1; end
      if (!done) mhand = (mhand + 1) % N;
    end
    mst[v] = mvt; mrb[v] = 1; mhand = (v + 1) % N;
  endfunction

  task automatic step(input bit t, input bit r, input int f);
    @(negedge clk);
    tick = t; ref_valid = r; ref_idx = IW'(f);
    @(negedge clk);
    tick = 0; ref_valid = 0;
    if (t) mvt = (mvt + 1) & MASK;
    if (r) mrb[f] = 1;
  endtask

  task automatic do_evict(input bit hold2);
    int ev, ek, n;
    model_scan(ev, ek);
    @(negedge clk); evict_req = 1;
    @(negedge clk); if (!hold2) evict_req = 0;
    chk(busy == 1, "R10 busy after request", busy, 1);
    n = 0;
    while (!victim_valid && n < N + 3) begin
      @(negedge clk); n++;
      if (n == 1) evict_req = 0;  // R4: second request seen while busy is ignored
    end
    evict_req = 0;
    chk(victim_valid == 1, "R8 strobe", victim_valid, 1);
    chk(int'(victim_idx) == ev, "R6/R7 victim index", victim_idx, ev);
    chk(n == ek, "R8 latency (frames examined)", n, ek);
    chk(busy == 0, "R10 busy low at strobe", busy, 0);
    @(negedge clk);
    chk(victim_valid == 0, "R8 one-cycle pulse", victim_valid, 0);
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin mrb[i] = 0; mst[i] = 0; end
    mvt = 0; mhand = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(victim_valid == 0, "R1 no strobe after reset", victim_valid, 0);

    // R7: all ages 0, thresh 0 -> fallback to first examined frame, full sweep
    thresh = 0;
    do_evict(0);
    // R6: age greater than window taken immediately
    repeat (3) step(1, 0, 0);
    thresh = 2;
    do_evict(0);
    // R6 boundary: age equal to window does not qualify
    thresh = 3;
    do_evict(0);
    // R5/R7: every flag set -> all cleared, victim is the start frame
    for (int f = 0; f < N; f++) step(0, 1, f);
    do_evict(1);
    // R3: referenced frame is passed over
    step(1, 1, 2);
    thresh = 0;
    do_evict(0);
    // R2: wrap of the 5-bit time counter
    repeat (40) step(1, 0, 0);
    thresh = 5'd20;
    do_evict(0);

    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) step(1, 0, 0);
      else if (op < 7) step($urandom_range(0, 1), 1, $urandom_range(0, N - 1));
      else begin
        thresh = TW'($urandom_range(0, 12));
        do_evict($urandom_range(0, 1));
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule